// File: doc/BRIEF.md
# Critical-Word-First Line Fill Controller

This block runs the refill of one cache line from memory after a miss. It takes a miss with a line address and the offset of the word the CPU wants. It issues one burst request to memory and then takes the returned words one beat at a time. Each beat is written straight into the cache data array. The beat that carries the wanted word is also sent to the CPU in the same cycle, so the CPU can resume before the line is complete.

There are two fill orders, chosen for each miss. In wrapped order the burst starts at the wanted word and runs through the line modulo its length, so the CPU is released on the first beat. In linear order the burst starts at word 0, and the CPU is released when the beat holding the wanted word arrives. While the fill runs, the CPU may probe the line being filled. A word that has already landed is served from a local copy. A word that has not landed reports a miss, and the CPU waits. Once the last word has been written, a completion pulse tells the cache that the line may be marked valid.

Top module: `line_fill_cwf`

## Requirements
- R1: After reset, `miss_ready` is 1, and `mem_req_valid`, `mem_rsp_ready`, `arr_we`, `cpu_rsp_valid` and `fill_done` are all 0.
- R2: A miss is accepted only when `miss_ready` is 1. `miss_ready` is 0 from the cycle after acceptance until the cycle after `fill_done`, and a miss presented during that time has no effect.
- R3: After a miss is accepted, `mem_req_valid` rises and holds `mem_req_line` equal to the miss line. `mem_req_start` is the requested word when `miss_wrap`=1 and 0 when `miss_wrap`=0. The request stays up until `mem_req_ready`.
- R4: Beat k (k = 0..7) of the burst writes array word (`mem_req_start` + k) mod 8 of the filling line, with the beat's data. There is one array write per beat, in the same cycle the beat is taken.
- R5: In wrapped mode, `cpu_rsp_valid` pulses with `cpu_rsp_data` equal to beat 0's data, in the cycle beat 0 is taken, and only once per fill.
- R6: In linear mode, `cpu_rsp_valid` pulses exactly once, in the cycle that beat number equal to the requested word is taken, carrying that beat's data.
- R7: A beat is taken only when `mem_rsp_valid` and `mem_rsp_ready` are both 1. `mem_rsp_ready` is 0 outside the burst phase, and a stalled cycle writes nothing and does not advance the beat count.
- R8: `fill_done` pulses for one cycle, the cycle after the eighth beat, with `fill_line` equal to the filled line. `miss_ready` returns the cycle after that.
- R9: A CPU probe (`cpu_rd_valid`, `cpu_rd_line`, `cpu_rd_word`) during a fill sets `cpu_rd_hit` with the word's data only if that word was taken in an earlier cycle of this fill. Probes of words not yet taken, of another line, or outside a fill report no hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Miss request present |
| miss_ready | output | 1 | Controller idle and able to take a miss |
| miss_line | input | LINE_AW | Line address of the miss |
| miss_word | input | OFF_W | Requested word within the line |
| miss_wrap | input | 1 | 1 = wrapped order, 0 = linear order |
| mem_req_valid | output | 1 | Burst request to memory |
| mem_req_ready | input | 1 | Memory accepts the burst request |
| mem_req_line | output | LINE_AW | Line address of the burst |
| mem_req_start | output | OFF_W | Word the burst begins at |
| mem_rsp_valid | input | 1 | Memory beat present |
| mem_rsp_ready | output | 1 | Controller takes beats |
| mem_rsp_data | input | DATA_W | Beat data |
| cpu_rsp_valid | output | 1 | Requested word delivered to the CPU |
| cpu_rsp_data | output | DATA_W | Requested word data |
| cpu_rd_valid | input | 1 | CPU probe of the filling line |
| cpu_rd_line | input | LINE_AW | Probe line address |
| cpu_rd_word | input | OFF_W | Probe word |
| cpu_rd_hit | output | 1 | Probed word has already arrived |
| cpu_rd_data | output | DATA_W | Probed word data |
| arr_we | output | 1 | Cache data array write strobe |
| arr_line | output | LINE_AW | Array write line |
| arr_word | output | OFF_W | Array write word |
| arr_data | output | DATA_W | Array write data |
| fill_done | output | 1 | Line complete, may be marked valid |
| fill_line | output | LINE_AW | Line that completed |

## Verification
The bench uses the default build: 8 words per line, 32-bit data and 26-bit line addresses. With only 8 offsets and two orders, all 16 combinations of mode and requested word can be filled one after another. Each beat's array word and release cycle are checked against modular arithmetic on the start word. Stalls are placed at offsets that depend on the word, and each beat carries a probe of a different word. Together these cover release on every beat position and probe hits on both sides of the arrival boundary.

// File: rtl/lcf_pkg.sv
package lcf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_FILL = 2'd2,
        ST_DONE = 2'd3
    } lcf_state_e;

    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_WRAP   = 1'b1
    } lcf_order_e;

    // Offset arithmetic relies on a power-of-two line length.
    function automatic bit is_pow2(input int n);
        return (n > 1) && ((n & (n - 1)) == 0);
    endfunction

endpackage

// File: rtl/lcf_ctrl.sv
module lcf_ctrl
    import lcf_pkg::*;
#(
    parameter int LINE_AW = 26,
    parameter int WORDS   = 8,
    localparam int OFF_W  = $clog2(WORDS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               miss_valid,
    input  logic [LINE_AW-1:0] miss_line,
    input  logic [OFF_W-1:0]   miss_word,
    input  logic               miss_wrap,
    input  logic               mem_req_ready,
    input  logic               mem_rsp_valid,
    output lcf_state_e         state,
    output logic               miss_take,
    output logic               beat_take,
    output logic [OFF_W-1:0]   beat,
    output logic [LINE_AW-1:0] cur_line,
    output logic [OFF_W-1:0]   cur_word,
    output logic [OFF_W-1:0]   fetch_start
);

    lcf_order_e order_sel;

    always_comb begin
        order_sel = lcf_order_e'(miss_wrap);
        miss_take = (state == ST_IDLE) && miss_valid;
        beat_take = (state == ST_FILL) && mem_rsp_valid;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            beat        <= '0;
            cur_line    <= '0;
            cur_word    <= '0;
            fetch_start <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (miss_take) begin
                        cur_line    <= miss_line;
                        cur_word    <= miss_word;
                        fetch_start <= (order_sel == ORD_WRAP) ? miss_word : '0;
                        state       <= ST_REQ;
                    end
                end
                ST_REQ: begin
                    if (mem_req_ready) begin
                        beat  <= '0;
                        state <= ST_FILL;
                    end
                end
                ST_FILL: begin
                    if (beat_take) begin
                        beat <= beat + 1'b1;
                        if (beat == OFF_W'(WORDS - 1)) begin
                            state <= ST_DONE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/lcf_order.sv
module lcf_order #(
    parameter int WORDS  = 8,
    localparam int OFF_W = $clog2(WORDS)
) (
    input  logic [OFF_W-1:0] fetch_start,
    input  logic [OFF_W-1:0] beat,
    input  logic [OFF_W-1:0] want_word,
    output logic [OFF_W-1:0] word_idx,
    output logic             is_wanted
);

    // The add wraps naturally at the line length (power of two).
    always_comb begin
        word_idx  = fetch_start + beat;
        is_wanted = (word_idx == want_word);
    end

endmodule

// File: rtl/lcf_track.sv
module lcf_track #(
    parameter int DATA_W = 32,
    parameter int WORDS  = 8,
    localparam int OFF_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [OFF_W-1:0]  rd_idx,
    output logic              rd_landed,
    output logic [DATA_W-1:0] rd_data
);

    logic [WORDS-1:0]  landed;
    logic [DATA_W-1:0] copy [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                landed[g] <= 1'b0;
            end else if (wr_en && (wr_idx == OFF_W'(g))) begin
                landed[g] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == OFF_W'(g))) begin
                copy[g] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_landed = landed[rd_idx];
        rd_data   = copy[rd_idx];
    end

endmodule

// File: rtl/line_fill_cwf.sv
module line_fill_cwf
    import lcf_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int LINE_AW = 26,
    parameter int WORDS   = 8,
    localparam int OFF_W  = $clog2(WORDS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               miss_valid,
    output logic               miss_ready,
    input  logic [LINE_AW-1:0] miss_line,
    input  logic [OFF_W-1:0]   miss_word,
    input  logic               miss_wrap,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [LINE_AW-1:0] mem_req_line,
    output logic [OFF_W-1:0]   mem_req_start,
    input  logic               mem_rsp_valid,
    output logic               mem_rsp_ready,
    input  logic [DATA_W-1:0]  mem_rsp_data,
    output logic               cpu_rsp_valid,
    output logic [DATA_W-1:0]  cpu_rsp_data,
    input  logic               cpu_rd_valid,
    input  logic [LINE_AW-1:0] cpu_rd_line,
    input  logic [OFF_W-1:0]   cpu_rd_word,
    output logic               cpu_rd_hit,
    output logic [DATA_W-1:0]  cpu_rd_data,
    output logic               arr_we,
    output logic [LINE_AW-1:0] arr_line,
    output logic [OFF_W-1:0]   arr_word,
    output logic [DATA_W-1:0]  arr_data,
    output logic               fill_done,
    output logic [LINE_AW-1:0] fill_line
);

    if (!is_pow2(WORDS)) begin : g_bad_words
        $error("WORDS must be a power of two above 1");
    end

    lcf_state_e         state;
    logic               miss_take;
    logic               beat_take;
    logic [OFF_W-1:0]   beat;
    logic [LINE_AW-1:0] cur_line;
    logic [OFF_W-1:0]   cur_word;
    logic [OFF_W-1:0]   fetch_start;
    logic [OFF_W-1:0]   word_idx;
    logic               is_wanted;
    logic               rd_landed;
    logic               busy_fill;

    lcf_ctrl #(.LINE_AW(LINE_AW), .WORDS(WORDS)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .miss_valid   (miss_valid),
        .miss_line    (miss_line),
        .miss_word    (miss_word),
        .miss_wrap    (miss_wrap),
        .mem_req_ready(mem_req_ready),
        .mem_rsp_valid(mem_rsp_valid),
        .state        (state),
        .miss_take    (miss_take),
        .beat_take    (beat_take),
        .beat         (beat),
        .cur_line     (cur_line),
        .cur_word     (cur_word),
        .fetch_start  (fetch_start)
    );

    lcf_order #(.WORDS(WORDS)) u_order (
        .fetch_start(fetch_start),
        .beat       (beat),
        .want_word  (cur_word),
        .word_idx   (word_idx),
        .is_wanted  (is_wanted)
    );

    lcf_track #(.DATA_W(DATA_W), .WORDS(WORDS)) u_track (
        .clk      (clk),
        .rst      (rst),
        .clear    (miss_take),
        .wr_en    (beat_take),
        .wr_idx   (word_idx),
        .wr_data  (mem_rsp_data),
        .rd_idx   (cpu_rd_word),
        .rd_landed(rd_landed),
        .rd_data  (cpu_rd_data)
    );

    always_comb begin
        busy_fill     = (state == ST_FILL) || (state == ST_DONE);
        miss_ready    = (state == ST_IDLE);
        mem_req_valid = (state == ST_REQ);
        mem_req_line  = cur_line;
        mem_req_start = fetch_start;
        mem_rsp_ready = (state == ST_FILL);
        arr_we        = beat_take;
        arr_line      = cur_line;
        arr_word      = word_idx;
        arr_data      = mem_rsp_data;
        cpu_rsp_valid = beat_take && is_wanted;
        cpu_rsp_data  = mem_rsp_data;
        cpu_rd_hit    = cpu_rd_valid && busy_fill && (cpu_rd_line == cur_line) && rd_landed;
        fill_done     = (state == ST_DONE);
        fill_line     = cur_line;
    end

endmodule

// File: rtl/lcf_fill_checker.sv
module lcf_fill_checker #(
    parameter int DATA_W  = 32,
    parameter int LINE_AW = 26,
    parameter int WORDS   = 8,
    localparam int OFF_W  = $clog2(WORDS)
) (
    input logic               clk,
    input logic               rst,
    input logic               miss_ready,
    input logic               mem_req_valid,
    input logic               mem_req_ready,
    input logic [LINE_AW-1:0] mem_req_line,
    input logic [OFF_W-1:0]   mem_req_start,
    input logic               mem_rsp_valid,
    input logic               mem_rsp_ready,
    input logic               cpu_rsp_valid,
    input logic [DATA_W-1:0]  cpu_rsp_data,
    input logic               cpu_rd_valid,
    input logic               cpu_rd_hit,
    input logic               arr_we,
    input logic [DATA_W-1:0]  arr_data,
    input logic               fill_done
);

    logic [OFF_W:0] beats_seen;
    logic           released;

    always_ff @(posedge clk) begin
        if (rst || (mem_req_valid && mem_req_ready)) begin
            beats_seen <= '0;
            released   <= 1'b0;
        end else begin
            if (arr_we) beats_seen <= beats_seen + 1'b1;
            if (cpu_rsp_valid) released <= 1'b1;
        end
    end

    a_r1_phase_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0({miss_ready, mem_req_valid, mem_rsp_ready, fill_done}));

    a_r2_busy_blocks_miss: assert property (@(posedge clk) disable iff (rst)
        mem_rsp_ready |-> !miss_ready);

    a_r3_req_held: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_line) && $stable(mem_req_start)));

    a_r7_write_needs_handshake: assert property (@(posedge clk) disable iff (rst)
        arr_we |-> (mem_rsp_valid && mem_rsp_ready));

    a_r5_release_is_beat: assert property (@(posedge clk) disable iff (rst)
        cpu_rsp_valid |-> (arr_we && (cpu_rsp_data == arr_data)));

    a_r6_single_release: assert property (@(posedge clk) disable iff (rst)
        cpu_rsp_valid |-> !released);

    a_r8_done_after_all_beats: assert property (@(posedge clk) disable iff (rst)
        fill_done |-> ((beats_seen == (OFF_W+1)'(WORDS)) && released));

    a_r9_hit_needs_probe: assert property (@(posedge clk) disable iff (rst)
        cpu_rd_hit |-> cpu_rd_valid);

endmodule

bind line_fill_cwf lcf_fill_checker #(
    .DATA_W (DATA_W),
    .LINE_AW(LINE_AW),
    .WORDS  (WORDS)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .miss_ready   (miss_ready),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_line (mem_req_line),
    .mem_req_start(mem_req_start),
    .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_ready(mem_rsp_ready),
    .cpu_rsp_valid(cpu_rsp_valid),
    .cpu_rsp_data (cpu_rsp_data),
    .cpu_rd_valid (cpu_rd_valid),
    .cpu_rd_hit   (cpu_rd_hit),
    .arr_we       (arr_we),
    .arr_data     (arr_data),
    .fill_done    (fill_done)
);

// File: tb/sim_line_fill_cwf.sv
`timescale 1ns/1ps
module sim_line_fill_cwf;

    localparam int DATA_W  = 32;
    localparam int LINE_AW = 26;
    localparam int WORDS   = 8;
    localparam int OFF_W   = 3;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               miss_valid = 1'b0;
    logic               miss_ready;
    logic [LINE_AW-1:0] miss_line = '0;
    logic [OFF_W-1:0]   miss_word = '0;
    logic               miss_wrap = 1'b0;
    logic               mem_req_valid;
    logic               mem_req_ready = 1'b0;
    logic [LINE_AW-1:0] mem_req_line;
    logic [OFF_W-1:0]   mem_req_start;
    logic               mem_rsp_valid = 1'b0;
    logic               mem_rsp_ready;
    logic [DATA_W-1:0]  mem_rsp_data = '0;
    logic               cpu_rsp_valid;
    logic [DATA_W-1:0]  cpu_rsp_data;
    logic               cpu_rd_valid = 1'b0;
    logic [LINE_AW-1:0] cpu_rd_line = '0;
    logic [OFF_W-1:0]   cpu_rd_word = '0;
    logic               cpu_rd_hit;
    logic [DATA_W-1:0]  cpu_rd_data;
    logic               arr_we;
    logic [LINE_AW-1:0] arr_line;
    logic [OFF_W-1:0]   arr_word;
    logic [DATA_W-1:0]  arr_data;
    logic               fill_done;
    logic [LINE_AW-1:0] fill_line;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    line_fill_cwf #(.DATA_W(DATA_W), .LINE_AW(LINE_AW), .WORDS(WORDS)) u0 (.*);

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [DATA_W-1:0] word_val(input logic [LINE_AW-1:0] ln, input int i);
        return {ln[23:0], 5'd0, i[2:0]};
    endfunction

    task automatic run_fill(input int wrap, input int w);
        logic [LINE_AW-1:0] ln;
        int start;
        int releases;
        ln       = LINE_AW'(26'h100 + wrap * 16 + w * 3);
        start    = (wrap != 0) ? w : 0;
        releases = 0;

        @(negedge clk);
        miss_valid = 1'b1; miss_line = ln; miss_word = w[2:0]; miss_wrap = wrap[0];
        #1 check(miss_ready == 1'b1, "R2 idle ready", 64'(miss_ready), 64'd1);
        @(negedge clk);
        miss_valid = 1'b0;
        #1;
        check(mem_req_valid == 1'b1, "R3 request raised", 64'(mem_req_valid), 64'd1);
        check(mem_req_line == ln, "R3 request line", 64'(mem_req_line), 64'(ln));
        check(int'(mem_req_start) == start, "R3 start word", 64'(mem_req_start), 64'(start));
        check(miss_ready == 1'b0, "R2 busy not ready", 64'(miss_ready), 64'd0);
        if (w % 2 == 1) begin
            mem_rsp_valid = 1'b1; mem_rsp_data = 32'hDEAD_BEEF;
            #1 check(arr_we == 1'b0 && mem_rsp_ready == 1'b0, "R7 no beat before burst",
                     64'(arr_we), 64'd0);
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            #1 check(mem_req_valid == 1'b1, "R3 request held", 64'(mem_req_valid), 64'd1);
        end
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;

        for (int k = 0; k < WORDS; k++) begin
            int idx;
            int q;
            int pos;
            bit exp_rel;
            bit exp_hit;
            if ((k + w) % 3 == 0) begin
                mem_rsp_valid = 1'b0;
                miss_valid = 1'b1; miss_line = ln + 26'd7; miss_word = 3'(w + 1);
                #1 check(mem_rsp_ready == 1'b1 && arr_we == 1'b0 && cpu_rsp_valid == 1'b0,
                         "R7 stall writes nothing", 64'(arr_we), 64'd0);
                @(negedge clk);
            end
            idx = (start + k) % WORDS;
            q   = (k * 3 + w) % WORDS;
            pos = (q - start + WORDS) % WORDS;
            exp_rel = (idx == w);
            exp_hit = (pos < k);
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = word_val(ln, idx);
            cpu_rd_valid  = 1'b1; cpu_rd_line = ln; cpu_rd_word = q[2:0];
            #1;
            check(arr_we == 1'b1, "R4 write on beat", 64'(arr_we), 64'd1);
            check(int'(arr_word) == idx && arr_line == ln, "R4 beat word order",
                  64'(arr_word), 64'(idx));
            check(arr_data == word_val(ln, idx), "R4 beat data", 64'(arr_data),
                  64'(word_val(ln, idx)));
            if (wrap != 0)
                check(cpu_rsp_valid == exp_rel && (k == 0) == exp_rel,
                      "R5 wrapped release on beat 0", 64'(cpu_rsp_valid), 64'(exp_rel));
            else
                check(cpu_rsp_valid == exp_rel, "R6 linear release at word beat",
                      64'(cpu_rsp_valid), 64'(exp_rel));
            if (cpu_rsp_valid) begin
                releases++;
                check(cpu_rsp_data == word_val(ln, w), "R5 released data",
                      64'(cpu_rsp_data), 64'(word_val(ln, w)));
            end
            check(cpu_rd_hit == exp_hit, "R9 probe landed only", 64'(cpu_rd_hit), 64'(exp_hit));
            if (exp_hit)
                check(cpu_rd_data == word_val(ln, q), "R9 probe data",
                      64'(cpu_rd_data), 64'(word_val(ln, q)));
            @(negedge clk);
        end

        mem_rsp_valid = 1'b0;
        miss_valid    = 1'b0;
        cpu_rd_valid  = 1'b1; cpu_rd_line = ln + 26'd1; cpu_rd_word = 3'(w);
        #1;
        check(fill_done == 1'b1 && fill_line == ln, "R8 done after last beat",
              64'(fill_done), 64'd1);
        check(miss_ready == 1'b0, "R8 not ready during done", 64'(miss_ready), 64'd0);
        check(cpu_rd_hit == 1'b0, "R9 other line no hit", 64'(cpu_rd_hit), 64'd0);
        check(releases == 1, "R6 one release per fill", 64'(releases), 64'd1);
        @(negedge clk);
        cpu_rd_line = ln;
        #1;
        check(fill_done == 1'b0 && miss_ready == 1'b1, "R8 single pulse then idle",
              64'(fill_done), 64'd0);
        check(mem_req_valid == 1'b0, "R2 refused miss left no request",
              64'(mem_req_valid), 64'd0);
        check(cpu_rd_hit == 1'b0, "R9 idle no hit", 64'(cpu_rd_hit), 64'd0);
        cpu_rd_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check(miss_ready == 1'b1, "R1 reset ready", 64'(miss_ready), 64'd1);
        check(mem_req_valid == 1'b0 && mem_rsp_ready == 1'b0, "R1 reset no request",
              64'(mem_req_valid), 64'd0);
        check(arr_we == 1'b0 && cpu_rsp_valid == 1'b0 && fill_done == 1'b0,
              "R1 reset quiet outputs", 64'(fill_done), 64'd0);
        for (int wrap = 0; wrap < 2; wrap++) begin
            for (int w = 0; w < WORDS; w++) begin
                run_fill(wrap, w);
            end
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule